// File: doc/BRIEF.md
# Posted-Write Register Bridge

This block connects a fast bus clock domain to a slower functional clock domain. The functional domain holds a bank of timer registers that the counter logic uses. Every register that crosses the boundary has its own hand-over lane. A lane keeps the written word in a bus-side holding register. It then hands the word across with a toggle request and gets a toggle acknowledge back. One flag per lane shows whether a transfer is still in flight. Software reads these flags as a write-pending word and waits on the relevant flag, with a bounded number of polls, before it touches that register again.

The bridge has two completion modes, chosen by a bit in the interface control word. In posted mode a bus write finishes in the cycle it is presented, and the crossing happens in the background. A write to a lane that is still busy is dropped. In non-posted mode the bus handshake stalls until the word has landed in the functional domain. Software can also ask for a soft reset of the functional registers through the interface control word. It then polls a reset-done status bit.

The functional side sees each lane's current value on a flat output bus. It also gets a one-cycle update strobe per lane and a one-cycle strobe when the soft reset has been applied.

Top module: `pwb_top`

## Requirements
- R1: After bus and functional reset, the interface control word reads 0 (non-posted mode), the status word reads 1 (reset done), the write-pending word reads 0 and every functional register is 0.
- R2: Address map on byte addresses: interface control at 0x00 (bit 2 = posted mode, bit 1 = soft-reset request, write-only), status at 0x04 (bit 0 = reset done), write-pending at 0x08, and synchronised register k at 0x40 + 4k. Pending bit k belongs to register k, with lanes 0..9 being control, counter, load, trigger, match and five tick-trim registers. Reads of any other address return 0, and writes to them change nothing.
- R3: In posted mode, a write to a synchronised register completes with ready high in the cycle it is presented and sets pending bit k. Several lanes can be pending at once.
- R4: A pending bit clears only after the functional domain has taken the value. The value appears in slice k of `fn_regs`, together with a single one-cycle `fn_upd[k]` strobe per accepted write.
- R5: A posted write to a register whose pending bit is set is dropped: it causes no functional update and leaves the held value unchanged.
- R6: In non-posted mode, ready stays low until the written word has crossed, and that lane's pending bit reads 0 right afterwards. A non-posted write to a lane that is still pending first waits for it, and then performs its own transfer.
- R7: The holding register of a lane stays stable while its pending bit is set. A read of a synchronised register's address returns the last accepted value.
- R8: A write to interface control with bit 1 set (for example 0x06) drops reset-done to 0. It clears every functional register with one `fn_soft_rst` strobe, and reset-done then returns to 1. The posted bit takes bit 2 of the same write. A request made while reset-done is 0 is ignored.
- R9: A write that arrives in the cycle in which the same lane's pending bit has just cleared is accepted. Under a continuous write stream, successive values keep landing in the order they were written.
- R10: A functional register changes only on that lane's update strobe or on a soft reset. Lanes that are never written stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| fn_clk | input | 1 | Functional clock |
| fn_rst | input | 1 | Synchronous active-high reset, functional domain |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | DW | Read data, valid while ready is high on a read |
| fn_regs | output | NSYNC*DW | Functional-domain register values, lane k at bits k*DW upward |
| fn_upd | output | NSYNC | One-cycle strobe per lane when a new value lands |
| fn_soft_rst | output | 1 | One-cycle strobe when the soft reset clears the registers |

## Verification
Two events can fall in the same bus cycle: the acknowledge that clears a lane's pending flag, and a new posted write to that same lane. The bench provokes this by streaming one write per cycle to a single lane for sixty cycles. Each stream write carries an increasing value, so a write is bound to arrive in the very cycle the flag drops. The bench then judges that several values landed, that they rise strictly and stay within the values it wrote, and that the final readback, the functional slice and the last landed value all agree.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    // Byte addresses of the bridge words
    localparam int ADDR_ICTL  = 'h00;
    localparam int ADDR_STAT  = 'h04;
    localparam int ADDR_WPEND = 'h08;
    localparam int SYNC_BASE  = 'h40;

    // Bit positions inside the interface control word
    localparam int ICTL_SRST_BIT   = 1;
    localparam int ICTL_POSTED_BIT = 2;

    // Lane order as decoded by software in the write-pending word
    localparam int LANE_CTRL   = 0;
    localparam int LANE_COUNT  = 1;
    localparam int LANE_LOAD   = 2;
    localparam int LANE_TRIG   = 3;
    localparam int LANE_MATCH  = 4;
    localparam int LANE_TICK0  = 5;

    typedef enum logic {
        NP_IDLE = 1'b0,
        NP_WAIT = 1'b1
    } np_state_e;

    typedef struct packed {
        logic       hit_ictl;
        logic       hit_stat;
        logic       hit_pend;
        logic       hit_sync;
        logic [7:0] lane;
    } acc_dec_t;

    function automatic acc_dec_t decode_addr(input logic [31:0] a, input int nsync);
        acc_dec_t d;
        d = '0;
        if (a == 32'(ADDR_ICTL))  d.hit_ictl = 1'b1;
        if (a == 32'(ADDR_STAT))  d.hit_stat = 1'b1;
        if (a == 32'(ADDR_WPEND)) d.hit_pend = 1'b1;
        if (a >= 32'(SYNC_BASE) && a < 32'(SYNC_BASE + 4 * nsync) && a[1:0] == 2'b00) begin
            d.hit_sync = 1'b1;
            d.lane     = 8'((a - 32'(SYNC_BASE)) >> 2);
        end
        return d;
    endfunction

endpackage

// File: rtl/pwb_sync.sv
module pwb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwb_lane.sv
module pwb_lane #(
    parameter int DW     = 32,
    parameter int STAGES = 2
) (
    // bus side
    input  logic          bus_clk,
    input  logic          bus_rst,
    input  logic          launch,
    input  logic [DW-1:0] wdata,
    output logic          pending,
    output logic          ack_evt,
    output logic [DW-1:0] hold,
    // functional side
    input  logic          fn_clk,
    input  logic          fn_rst,
    input  logic          soft_clr,
    output logic [DW-1:0] fn_q,
    output logic          fn_upd
);
    logic req_t, ack_s, ack_d;
    logic req_s, req_d, ack_t;
    logic take;

    // bus domain: request toggle and holding register
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_t <= 1'b0;
            hold  <= '0;
            ack_d <= 1'b0;
        end else begin
            ack_d <= ack_s;
            if (launch) begin
                req_t <= ~req_t;
                hold  <= wdata;
            end
        end
    end

    pwb_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (ack_t),
        .q   (ack_s)
    );

    assign pending = req_t ^ ack_s;
    assign ack_evt = ack_s ^ ack_d;

    // functional domain: capture on request edge, return acknowledge
    pwb_sync #(.STAGES(STAGES)) u_req_sync (
        .clk (fn_clk),
        .rst (fn_rst),
        .d   (req_t),
        .q   (req_s)
    );

    assign take = req_s ^ req_d;

    always_ff @(posedge fn_clk) begin
        if (fn_rst) begin
            req_d  <= 1'b0;
            ack_t  <= 1'b0;
            fn_q   <= '0;
            fn_upd <= 1'b0;
        end else begin
            req_d  <= req_s;
            fn_upd <= take;
            if (take) begin
                fn_q  <= hold;
                ack_t <= ~ack_t;
            end else if (soft_clr) begin
                fn_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/pwb_srst.sv
module pwb_srst #(
    parameter int STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic req,
    output logic done,
    input  logic fn_clk,
    input  logic fn_rst,
    output logic clr_evt,
    output logic clr_pulse
);
    logic rq_t, ak_s;
    logic rq_s, rq_d, ak_t;

    always_ff @(posedge bus_clk) begin
        if (bus_rst)          rq_t <= 1'b0;
        else if (req && done) rq_t <= ~rq_t;
    end

    pwb_sync #(.STAGES(STAGES)) u_ak_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (ak_t),
        .q   (ak_s)
    );

    assign done = (rq_t == ak_s);

    pwb_sync #(.STAGES(STAGES)) u_rq_sync (
        .clk (fn_clk),
        .rst (fn_rst),
        .d   (rq_t),
        .q   (rq_s)
    );

    assign clr_evt = rq_s ^ rq_d;

    always_ff @(posedge fn_clk) begin
        if (fn_rst) begin
            rq_d      <= 1'b0;
            ak_t      <= 1'b0;
            clr_pulse <= 1'b0;
        end else begin
            rq_d      <= rq_s;
            clr_pulse <= clr_evt;
            if (clr_evt) ak_t <= ~ak_t;
        end
    end
endmodule

// File: rtl/pwb_busctl.sv
module pwb_busctl
    import pwb_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int NSYNC = 10,
    localparam int LW   = (NSYNC > 1) ? $clog2(NSYNC) : 1
) (
    input  logic                bus_clk,
    input  logic                bus_rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [AW-1:0]       bus_addr,
    input  logic [1:0]          ictl_bits,   // wdata bits 2:1
    output logic                bus_ready,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NSYNC-1:0]    pending,
    input  logic [NSYNC-1:0]    ack_evt,
    input  logic [NSYNC*DW-1:0] hold_flat,
    input  logic                srst_done,
    output logic [NSYNC-1:0]    launch,
    output logic                srst_req,
    output logic                posted
);
    np_state_e state;
    logic [LW-1:0] lane_q;
    acc_dec_t dec;
    logic [LW-1:0] lane_ix;
    logic ictl_wr;

    always_comb begin
        dec     = decode_addr(32'(bus_addr), NSYNC);
        lane_ix = LW'(dec.lane);
    end

    always_comb begin
        launch   = '0;
        bus_ready = 1'b0;
        srst_req = 1'b0;
        ictl_wr  = 1'b0;
        unique case (state)
            NP_IDLE: begin
                if (bus_valid) begin
                    if (bus_write && dec.hit_sync) begin
                        if (!pending[lane_ix]) launch[lane_ix] = 1'b1;
                        bus_ready = posted;
                    end else begin
                        bus_ready = 1'b1;
                        if (bus_write && dec.hit_ictl) begin
                            ictl_wr  = 1'b1;
                            srst_req = ictl_bits[0];
                        end
                    end
                end
            end
            NP_WAIT: bus_ready = ack_evt[lane_q];
            default: bus_ready = 1'b0;
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_write) begin
            if (dec.hit_ictl)      bus_rdata = DW'(posted) << ICTL_POSTED_BIT;
            else if (dec.hit_stat) bus_rdata = DW'(srst_done);
            else if (dec.hit_pend) bus_rdata = DW'(pending);
            else if (dec.hit_sync) bus_rdata = hold_flat[lane_ix*DW +: DW];
        end
    end

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            state  <= NP_IDLE;
            lane_q <= '0;
            posted <= 1'b0;
        end else begin
            if (ictl_wr) posted <= ictl_bits[1];
            unique case (state)
                NP_IDLE: if (|launch && !posted) begin
                    state  <= NP_WAIT;
                    lane_q <= lane_ix;
                end
                NP_WAIT: if (ack_evt[lane_q]) state <= NP_IDLE;
                default: state <= NP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwb_top.sv
module pwb_top
    import pwb_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int NSYNC  = 10,
    parameter int STAGES = 2
) (
    input  logic                bus_clk,
    input  logic                bus_rst,
    input  logic                fn_clk,
    input  logic                fn_rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic                bus_ready,
    output logic [DW-1:0]       bus_rdata,
    output logic [NSYNC*DW-1:0] fn_regs,
    output logic [NSYNC-1:0]    fn_upd,
    output logic                fn_soft_rst
);
    logic [NSYNC-1:0]    wpend;
    logic [NSYNC-1:0]    ack_evt;
    logic [NSYNC-1:0]    launch;
    logic [NSYNC*DW-1:0] hold_flat;
    logic                srst_req;
    logic                srst_done;
    logic                srst_evt;
    logic                posted_q;

    pwb_busctl #(.AW(AW), .DW(DW), .NSYNC(NSYNC)) u_ctl (
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .ictl_bits (bus_wdata[ICTL_POSTED_BIT:ICTL_SRST_BIT]),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .pending   (wpend),
        .ack_evt   (ack_evt),
        .hold_flat (hold_flat),
        .srst_done (srst_done),
        .launch    (launch),
        .srst_req  (srst_req),
        .posted    (posted_q)
    );

    pwb_srst #(.STAGES(STAGES)) u_srst (
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .req       (srst_req),
        .done      (srst_done),
        .fn_clk    (fn_clk),
        .fn_rst    (fn_rst),
        .clr_evt   (srst_evt),
        .clr_pulse (fn_soft_rst)
    );

    for (genvar k = 0; k < NSYNC; k++) begin : g_lane
        pwb_lane #(.DW(DW), .STAGES(STAGES)) u_lane (
            .bus_clk  (bus_clk),
            .bus_rst  (bus_rst),
            .launch   (launch[k]),
            .wdata    (bus_wdata),
            .pending  (wpend[k]),
            .ack_evt  (ack_evt[k]),
            .hold     (hold_flat[k*DW +: DW]),
            .fn_clk   (fn_clk),
            .fn_rst   (fn_rst),
            .soft_clr (srst_evt),
            .fn_q     (fn_regs[k*DW +: DW]),
            .fn_upd   (fn_upd[k])
        );
    end
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
    import pwb_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int NSYNC = 10
) (
    input logic                bus_clk,
    input logic                bus_rst,
    input logic                fn_clk,
    input logic                fn_rst,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [AW-1:0]       bus_addr,
    input logic                wdata_srst,
    input logic                bus_ready,
    input logic                posted,
    input logic [NSYNC-1:0]    pending,
    input logic [NSYNC*DW-1:0] hold_flat,
    input logic                srst_done,
    input logic [NSYNC*DW-1:0] fn_regs,
    input logic [NSYNC-1:0]    fn_upd,
    input logic                fn_soft_rst
);
    acc_dec_t dec;
    logic [7:0] lane_d;

    always_comb dec = decode_addr(32'(bus_addr), NSYNC);

    always_ff @(posedge bus_clk) begin
        if (bus_rst) lane_d <= '0;
        else         lane_d <= dec.lane;
    end

    // R3
    pend_rise_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (|(pending & ~$past(pending))) |-> $past(bus_valid && bus_write));

    // R3
    posted_nostall_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (posted && bus_valid && bus_write && dec.hit_sync) |-> bus_ready);

    // R6
    np_done_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (!posted && bus_valid && bus_write && bus_ready && dec.hit_sync) |=> !pending[lane_d]);

    // R8
    srst_fall_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $fell(srst_done) |-> $past(bus_valid && bus_write && dec.hit_ictl && wdata_srst));

    // R10
    fn_change_chk: assert property (@(posedge fn_clk) disable iff (fn_rst)
        (fn_regs != $past(fn_regs)) |-> (|fn_upd || fn_soft_rst));

    for (genvar k = 0; k < NSYNC; k++) begin : g_hold
        // R7
        hold_stable_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
            (pending[k] && $past(pending[k])) |-> $stable(hold_flat[k*DW +: DW]));
    end
endmodule

bind pwb_top pwb_checker #(.AW(AW), .DW(DW), .NSYNC(NSYNC)) u_pwb_chk (
    .bus_clk     (bus_clk),
    .bus_rst     (bus_rst),
    .fn_clk      (fn_clk),
    .fn_rst      (fn_rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .wdata_srst  (bus_wdata[1]),
    .bus_ready   (bus_ready),
    .posted      (posted_q),
    .pending     (wpend),
    .hold_flat   (hold_flat),
    .srst_done   (srst_done),
    .fn_regs     (fn_regs),
    .fn_upd      (fn_upd),
    .fn_soft_rst (fn_soft_rst)
);

// File: tb/pwb_top_bench.sv
module pwb_top_bench;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NS = 10;

    logic bclk = 0, fclk = 0;
    logic brst = 1, frst = 1;
    logic bus_valid = 0, bus_write = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic bus_ready;
    logic [DW-1:0] bus_rdata;
    logic [NS*DW-1:0] fn_regs;
    logic [NS-1:0] fn_upd;
    logic fn_soft_rst;

    always #2 bclk = ~bclk;
    always #7 fclk = ~fclk;

    pwb_top #(.AW(AW), .DW(DW), .NSYNC(NS)) u_pwb_top (
        .bus_clk(bclk), .bus_rst(brst), .fn_clk(fclk), .fn_rst(frst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .fn_regs(fn_regs), .fn_upd(fn_upd), .fn_soft_rst(fn_soft_rst)
    );

    int total = 0, bad = 0, srst_cnt = 0;
    bit stream = 0, finished = 0;
    logic [39:0] exp_q[$];       // {lane, value}
    logic [31:0] landed_q[$];

    function automatic logic [7:0] raddr(input int k);
        return 8'(8'h40 + 4 * k);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor on the functional side
    always @(negedge fclk) begin
        if (fn_soft_rst) srst_cnt++;
        for (int k = 0; k < NS; k++) begin
            if (!frst && fn_upd[k]) begin
                if (stream && k == 3) begin
                    landed_q.push_back(fn_regs[k*DW +: DW]);
                end else begin
                    int idx = -1;
                    for (int i = 0; i < exp_q.size(); i++)
                        if (idx < 0 && exp_q[i][39:32] == 8'(k)) idx = i;
                    total++;
                    if (idx < 0) begin
                        bad++;
                        $display("FAIL R4/R5 unexpected update lane %0d actual=%h expected=none", k, fn_regs[k*DW +: DW]);
                    end else begin
                        if (fn_regs[k*DW +: DW] != exp_q[idx][31:0]) begin
                            bad++;
                            $display("FAIL R4 lane %0d actual=%h expected=%h", k, fn_regs[k*DW +: DW], exp_q[idx][31:0]);
                        end
                        exp_q.delete(idx);
                    end
                end
            end
        end
    end

    task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
        @(negedge bclk);
        bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d; waits = 0;
        #1;
        while (!bus_ready && waits < 2000) begin
            @(negedge bclk); #1; waits++;
        end
        rd = bus_rdata;
        @(posedge bclk); #1;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] rd; int w;
        xfer(1'b1, a, d, rd, w);
    endtask

    task automatic rdv(input logic [7:0] a, output logic [31:0] rd);
        int w;
        xfer(1'b0, a, '0, rd, w);
    endtask

    task automatic wait_clear(input logic [31:0] mask, input string tag);
        logic [31:0] rd; int n = 0;
        rdv(8'h08, rd);
        while ((rd & mask) != 0 && n < 300) begin rdv(8'h08, rd); n++; end
        chk((rd & mask) == 0, tag, rd, 32'h0);
    endtask

    initial begin
        logic [31:0] rd;
        int w;
        repeat (6) @(posedge fclk);
        #1 brst = 0; frst = 0;
        repeat (3) @(posedge bclk);

        // R1 reset state
        rdv(8'h00, rd); chk(rd == 0, "R1 ictl", rd, 0);
        rdv(8'h04, rd); chk(rd == 1, "R1 status", rd, 1);
        rdv(8'h08, rd); chk(rd == 0, "R1 pending", rd, 0);
        chk(fn_regs == '0, "R1 fn_regs", fn_regs[31:0], 0);

        // R6 non-posted stall
        exp_q.push_back({8'd0, 32'hA5A5_0001});
        xfer(1'b1, raddr(0), 32'hA5A5_0001, rd, w);
        chk(w >= 2, "R6 stall cycles", w, 2);
        rdv(8'h08, rd); chk(rd == 0, "R6 pending after", rd, 0);

        // R2 unmapped access
        wr(8'h20, 32'hFFFF_FFFF);
        rdv(8'h20, rd); chk(rd == 0, "R2 unmapped read", rd, 0);
        wr(8'h08, 32'hFFFF_FFFF);
        rdv(8'h08, rd); chk(rd == 0, "R2 pending not writable", rd, 0);

        // R3 posted mode
        wr(8'h00, 32'h4);
        rdv(8'h00, rd); chk(rd == 4, "R2 posted bit", rd, 4);
        exp_q.push_back({8'd1, 32'h1111_2222});
        xfer(1'b1, raddr(1), 32'h1111_2222, rd, w);
        chk(w == 0, "R3 no stall", w, 0);
        rdv(8'h08, rd); chk(rd[1] == 1'b1, "R3 pending set", rd, 2);
        wait_clear(32'h2, "R4 pending clears");

        // R3 several lanes in flight
        for (int k = 0; k < 5; k++) begin
            exp_q.push_back({8'(k), 32'h5000_0000 + k});
            wr(raddr(k), 32'h5000_0000 + k);
        end
        rdv(8'h08, rd); chk(rd == 32'h1F, "R3 multi pending", rd, 32'h1F);
        wait_clear(32'h1F, "R4 multi clear");

        // R5 write to a pending lane is lost
        exp_q.push_back({8'd2, 32'hAAAA_0002});
        wr(raddr(2), 32'hAAAA_0002);
        wr(raddr(2), 32'hBBBB_0002);
        rdv(raddr(2), rd); chk(rd == 32'hAAAA_0002, "R5 hold unchanged", rd, 32'hAAAA_0002);
        wait_clear(32'h4, "R4 lane2 clear");
        repeat (8) @(posedge fclk);
        chk(fn_regs[2*DW +: DW] == 32'hAAAA_0002, "R5 fn value", fn_regs[2*DW +: DW], 32'hAAAA_0002);

        // R6 non-posted behind a pending posted write
        exp_q.push_back({8'd5, 32'hC0C0_0005});
        wr(raddr(5), 32'hC0C0_0005);
        wr(8'h00, 32'h0);
        exp_q.push_back({8'd5, 32'hD0D0_0005});
        xfer(1'b1, raddr(5), 32'hD0D0_0005, rd, w);
        chk(w >= 2, "R6 wait behind pending", w, 2);
        rdv(8'h08, rd); chk(rd == 0, "R6 pending zero", rd, 0);
        rdv(raddr(5), rd); chk(rd == 32'hD0D0_0005, "R7 readback", rd, 32'hD0D0_0005);

        // R9 streaming writes to one lane
        wr(8'h00, 32'h4);
        stream = 1;
        for (int i = 1; i <= 60; i++) wr(raddr(3), 32'(i));
        wait_clear(32'h8, "R9 stream clear");
        repeat (8) @(posedge fclk);
        stream = 0;
        chk(landed_q.size() >= 2, "R9 updates landed", landed_q.size(), 2);
        begin
            bit ok = 1;
            for (int i = 0; i < landed_q.size(); i++) begin
                if (landed_q[i] < 1 || landed_q[i] > 60) ok = 0;
                if (i > 0 && landed_q[i] <= landed_q[i-1]) ok = 0;
            end
            chk(ok, "R9 order", landed_q.size(), 0);
        end
        rdv(raddr(3), rd);
        if (landed_q.size() > 0) begin
            chk(rd == landed_q[$], "R7 last accepted", rd, landed_q[$]);
            chk(fn_regs[3*DW +: DW] == landed_q[$], "R9 fn value", fn_regs[3*DW +: DW], landed_q[$]);
        end

        // R10 untouched lanes
        chk(fn_regs[NS*DW-1:6*DW] == '0, "R10 untouched lanes", fn_regs[9*DW +: DW], 0);

        // R8 soft reset, second request ignored while busy
        wr(8'h00, 32'h6);
        rdv(8'h04, rd); chk(rd == 0, "R8 done low", rd, 0);
        wr(8'h00, 32'h6);
        begin
            int n = 0;
            rdv(8'h04, rd);
            while (rd != 1 && n < 300) begin rdv(8'h04, rd); n++; end
            chk(rd == 1, "R8 done returns", rd, 1);
        end
        repeat (10) @(posedge fclk);
        chk(srst_cnt == 1, "R8 single clear", srst_cnt, 1);
        chk(fn_regs == '0, "R8 regs cleared", fn_regs[31:0], 0);
        rdv(8'h00, rd); chk(rd == 4, "R8 posted bit", rd, 4);
        chk(exp_q.size() == 0, "R4 all updates seen", exp_q.size(), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bclk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule